// File: doc/BRIEF.md
# Router Slice Power-Gate Controller

This block decides, for one router, when the switchable half of the router (the gated slice) is powered and clocked. It watches the router's maximum buffer occupancy, an idle flag from the slice, a drained flag from the slice's buffers, and wake requests from upstream routers one or two hops away. It drives a power-switch enable, a clock-gate enable and one power acknowledge per neighbour. Neighbours send flits into the slice only while they see their acknowledge.

The controller has three states: Sleep, Wake-up and Active. From Sleep, a wake request or congestion (occupancy above the high threshold) starts a fixed charging period. At the end of that period every neighbour is acknowledged. In Active, a quiet router counts toward a sleep deadline. The router is quiet when its occupancy is under the low threshold or the slice reports idle. The acknowledges are withdrawn a few cycles before the deadline, so that nothing is in flight when power is removed. A wake request or congestion during that countdown cancels it.

Top module: `slice_pg_ctrl`

## Requirements
- R1: After reset the controller is in Sleep: `pwr_en`, `clk_en` and every `pwr_ack` bit are 0.
- R2: In Sleep, any bit of `wake_req` set makes `pwr_en` 1 after the next clock edge.
- R3: In Sleep, `max_occ` greater than `HI_TH` wakes the slice like a request does. `max_occ` equal to `HI_TH` does not wake it.
- R4: `clk_en` rises in the same cycle as the wake condition in Sleep, one cycle before `pwr_en`. `clk_en` is 1 whenever `pwr_en` is 1.
- R5: All `pwr_ack` bits go to 1 exactly `WAKE_LAT` clock edges after `pwr_en` rises, and stay 0 before that.
- R6: In Active, when the router is quiet (`max_occ` < `LO_TH` or `slice_idle` = 1) with no request and no congestion, counting from the first quiet edge:
  - `pwr_ack` drops to 0 after `IDLE_LIM - ACK_LEAD` edges.
  - `pwr_en` and `clk_en` drop after `IDLE_LIM` edges, if `slice_empty` = 1.
- R7: With `max_occ` from `LO_TH` to `HI_TH` inclusive and `slice_idle` = 0, the controller stays Active and keeps acknowledging, however long this lasts.
- R8: If `slice_empty` is 0 when the idle count completes, power stays on with `pwr_ack` at 0. Power drops on the first edge with `slice_empty` = 1.
- R9: A wake request or congestion during the countdown, including the window in which acknowledge is already low, cancels it. `pwr_ack` returns to 1 after the next edge and power stays on.
- R10: No `pwr_ack` bit is 1 while `pwr_en` is 0.
- R11: In Sleep with no request and no congestion, the controller stays in Sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| max_occ | input | OCC_W | Maximum buffer occupancy across the router's inputs |
| slice_idle | input | 1 | Gated slice is carrying no traffic |
| slice_empty | input | 1 | Gated slice buffers are drained |
| wake_req | input | NB | Wake requests from upstream neighbours |
| pwr_en | output | 1 | Power-switch enable for the gated slice |
| clk_en | output | 1 | Enable for the slice clock-gate cell |
| pwr_ack | output | NB | Per-neighbour acknowledge that the slice is usable |

## Verification
The hardest situation to reach is a cancellation inside the last `ACK_LEAD` cycles of the countdown. There the acknowledge is already low but power is still on, and the cancel must restore the acknowledge without a power cycle. The bench holds the router quiet through `slice_idle` for exactly enough edges to enter that window. It then raises a single wake request. After that it leaves `slice_empty` low at the deadline, which exercises the hold-until-drained path.

// File: rtl/slice_pg_ctrl.sv
module slice_pg_ctrl #(
  parameter int NB       = 4,
  parameter int OCC_W    = 4,
  parameter int HI_TH    = 10,
  parameter int LO_TH    = 3,
  parameter int WAKE_LAT = 10,
  parameter int IDLE_LIM = 16,
  parameter int ACK_LEAD = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OCC_W-1:0] max_occ,
  input  logic             slice_idle,
  input  logic             slice_empty,
  input  logic [NB-1:0]    wake_req,
  output logic             pwr_en,
  output logic             clk_en,
  output logic [NB-1:0]    pwr_ack
);

  localparam int WC_W = $clog2(WAKE_LAT + 1);
  localparam int IC_W = $clog2(IDLE_LIM + 1);
  localparam logic [WC_W-1:0] WC_END  = WC_W'(WAKE_LAT - 1);
  localparam logic [IC_W-1:0] IC_END  = IC_W'(IDLE_LIM - 1);
  localparam logic [IC_W-1:0] IC_DROP = IC_W'(IDLE_LIM - ACK_LEAD);

  typedef enum logic [1:0] {SLEEP = 2'd0, WAKE = 2'd1, ACTIVE = 2'd2} pstate_t;

  pstate_t         st;
  logic [WC_W-1:0] wcnt;
  logic [IC_W-1:0] icnt;

  logic congested, quiet, wake_trig, ack_on;

  assign congested = max_occ > OCC_W'(HI_TH);
  assign quiet     = (max_occ < OCC_W'(LO_TH)) || slice_idle;
  assign wake_trig = (|wake_req) || congested;
  assign ack_on    = (st == ACTIVE) && (icnt < IC_DROP);

  assign pwr_en  = st != SLEEP;
  assign clk_en  = pwr_en || wake_trig;
  assign pwr_ack = {NB{ack_on}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= SLEEP;
      wcnt <= '0;
      icnt <= '0;
    end else begin
      case (st)
        SLEEP: begin
          icnt <= '0;
          wcnt <= '0;
          if (wake_trig) st <= WAKE;
        end
        WAKE: begin
          if (wcnt == WC_END) begin
            st   <= ACTIVE;
            wcnt <= '0;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        ACTIVE: begin
          if (wake_trig || !quiet) begin
            icnt <= '0;
          end else if (icnt == IC_END) begin
            if (slice_empty) begin
              st   <= SLEEP;
              icnt <= '0;
            end
          end else begin
            icnt <= icnt + 1'b1;
          end
        end
        default: st <= SLEEP;
      endcase
    end
  end

  assert_ack_needs_power_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|pwr_ack) |-> pwr_en);

  assert_clock_covers_power_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_en |-> clk_en);

  assert_sleep_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SLEEP && !wake_trig) |=> (st == SLEEP));

  assert_sleep_exits_via_wake_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SLEEP && wake_trig) |=> (st == WAKE));

  assert_no_early_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en) |-> (pwr_ack == '0));

  assert_ack_gone_before_cut_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en) |-> ($past(pwr_ack) == '0));

  assert_cut_only_when_drained_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en) |-> $past(slice_empty));

endmodule

// File: tb/slice_pg_ctrl_bench.sv
module slice_pg_ctrl_bench;
  localparam int NB = 4, OCC_W = 4, HI_TH = 10, LO_TH = 3;
  localparam int WAKE_LAT = 10, IDLE_LIM = 16, ACK_LEAD = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [OCC_W-1:0] max_occ = 4'd5;
  logic slice_idle = 1'b0;
  logic slice_empty = 1'b1;
  logic [NB-1:0] wake_req = '0;
  logic pwr_en, clk_en;
  logic [NB-1:0] pwr_ack;

  int checks = 0;
  int errors = 0;
  int viol = 0;

  always #4 clk = ~clk;

  slice_pg_ctrl #(.NB(NB), .OCC_W(OCC_W), .HI_TH(HI_TH), .LO_TH(LO_TH),
    .WAKE_LAT(WAKE_LAT), .IDLE_LIM(IDLE_LIM), .ACK_LEAD(ACK_LEAD)) u_slice_pg_ctrl (
    .clk(clk), .rst_n(rst_n), .max_occ(max_occ), .slice_idle(slice_idle),
    .slice_empty(slice_empty), .wake_req(wake_req), .pwr_en(pwr_en),
    .clk_en(clk_en), .pwr_ack(pwr_ack));

  always @(negedge clk)
    if (rst_n && (|pwr_ack) && !pwr_en) viol++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    step(2);
    check("R1 pwr_en", pwr_en, 0);
    check("R1 clk_en", clk_en, 0);
    check("R1 pwr_ack", pwr_ack, 0);
    rst_n = 1'b1;
    step(5);
    check("R11 stays asleep", pwr_en, 0);
  endtask

  task automatic t_wake_by_request;
    wake_req = 4'b0010;
    #1;
    check("R4 early clock", clk_en, 1);
    check("R4 power still off", pwr_en, 0);
    step(1);
    check("R2 power on", pwr_en, 1);
    check("R5 no ack yet", pwr_ack, 0);
    step(WAKE_LAT - 1);
    check("R5 ack one edge early", pwr_ack, 0);
    step(1);
    check("R5 ack on time", pwr_ack, 4'hF);
    wake_req = '0;
    step(30);
    check("R7 mid occupancy stays active", pwr_ack, 4'hF);
    check("R7 power kept", pwr_en, 1);
  endtask

  task automatic t_countdown;
    max_occ = 4'd1;
    step(IDLE_LIM - ACK_LEAD - 1);
    check("R6 ack before drop", pwr_ack, 4'hF);
    step(1);
    check("R6 ack dropped", pwr_ack, 0);
    check("R6 power still on", pwr_en, 1);
    step(ACK_LEAD - 1);
    check("R6 power one edge before cut", pwr_en, 1);
    step(1);
    check("R6 power cut", pwr_en, 0);
    check("R6 clock cut", clk_en, 0);
    check("R6 ack low asleep", pwr_ack, 0);
  endtask

  task automatic t_wake_by_occupancy;
    max_occ = 4'(HI_TH);
    #1;
    check("R3 equal threshold no early clock", clk_en, 0);
    step(3);
    check("R3 equal threshold stays asleep", pwr_en, 0);
    max_occ = 4'(HI_TH + 1);
    #1;
    check("R4 clock on congestion", clk_en, 1);
    step(1);
    check("R3 congestion wakes", pwr_en, 1);
    step(WAKE_LAT);
    check("R5 ack after congestion wake", pwr_ack, 4'hF);
  endtask

  task automatic t_abort_and_drain;
    max_occ = 4'd5;
    slice_idle = 1'b1;
    step(IDLE_LIM - ACK_LEAD + 1);
    check("R6 idle flag counts down", pwr_ack, 0);
    wake_req = 4'b0001;
    step(1);
    check("R9 ack restored", pwr_ack, 4'hF);
    check("R9 power kept", pwr_en, 1);
    wake_req = '0;
    slice_empty = 1'b0;
    step(IDLE_LIM);
    check("R8 ack low while undrained", pwr_ack, 0);
    check("R8 power held", pwr_en, 1);
    step(5);
    check("R8 power still held", pwr_en, 1);
    slice_empty = 1'b1;
    step(1);
    check("R8 power cut after drain", pwr_en, 0);
  endtask

  initial begin
    t_reset();
    t_wake_by_request();
    t_countdown();
    t_wake_by_occupancy();
    t_abort_and_drain();
    check("R10 ack never without power", viol, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule